// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits beside a byte-wide asynchronous SRAM bus and listens for a command hidden in ordinary read traffic. The bus is sampled by a synchronous clock. Each falling edge of the active-low chip select that occurs with write enable inactive is one read access. Six such reads, at a fixed chain of addresses, form a command. The last address of the chain picks the operation: copy the SRAM into nonvolatile storage (save) or bring the nonvolatile image back into the SRAM (restore). A completed chain produces a single-clock request pulse, which goes to a separate transfer engine.

Chip select and write enable each pass through a two-flop synchroniser and then through falling-edge detection. Output enable plays no part. Any write access, and any read that does not hit the next expected address, drops the progress back to the start. A read of the first address of the chain always counts as a new first step. The save request is held back while a low-supply inhibit input is high. While the busy input is high, progress is held at zero and every access is ignored. A 3-bit step index shows progress for debug.

Top module: `seqcmd_detect`

## Requirements
- R1: After synchronous reset, step_idx is 0, and save_req and restore_req are both 0.
- R2: A read access is a falling edge of cs_n while wr_n is high. The chain is 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0. Each read that matches the next address raises step_idx by one, so step_idx counts the matched reads (0 to 5). The result appears on the third rising clock edge after cs_n falls.
- R3: When step_idx is 5, a read of 0x0F0F produces save_req high for exactly one clock. In that same clock step_idx reads 6, and on the following clock it returns to 0.
- R4: When step_idx is 5, a read of 0x0F0E produces restore_req high for exactly one clock. As with a save, step_idx reads 6 in that clock.
- R5: A read of any address other than the expected next one resets step_idx to 0 and issues no request. The one exception is address 0x0000, which sets step_idx to 1.
- R6: A write access resets step_idx to 0. A write access is either a falling edge of cs_n while wr_n is low, or a falling edge of wr_n while cs_n is low.
- R7: Repeating the read of the address that was just matched (a second cs_n edge on the same step) aborts the chain. step_idx becomes 0, or 1 if that address is 0x0000.
- R8: When low_supply is high during the sixth read, 0x0F0F produces no save_req and step_idx becomes 0. A restore (0x0F0E) is not affected by low_supply.
- R9: While busy is high, step_idx is 0 from the next clock on, no request is produced, and accesses do not advance step_idx.
- R10: Address changes and wr_n pulses while cs_n stays high leave step_idx unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | SRAM address bus, held stable through each access |
| cs_n | input | 1 | Active-low chip select from the bus |
| wr_n | input | 1 | Active-low write enable from the bus |
| busy | input | 1 | Transfer engine busy; clears and holds the progress |
| low_supply | input | 1 | Low-supply inhibit; suppresses save requests |
| save_req | output | 1 | One-clock request to save the SRAM to nonvolatile storage |
| restore_req | output | 1 | One-clock request to restore the SRAM from nonvolatile storage |
| step_idx | output | 3 | Matched-step count 0 to 5, and 6 in the request clock |

## Verification
Random traffic almost never completes a six-address chain, so the stimulus steers about half of the reads to the expected next address. The remaining reads go to 0x0000, to random addresses or to writes, with low_supply also toggled at random. This mix reaches the fifth step often enough to exercise save, restore and the inhibited save against a bench model. The hardest case to reach is a write that begins with wr_n falling while cs_n is already low after a matching read. Directed accesses drive that case, together with double-clocked steps, busy arriving mid-chain, and bus activity while the chip is not selected.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int ADDR_W  = 13;
    localparam int SEQ_LEN = 6;
    localparam int STEP_W  = $clog2(SEQ_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam addr_t START_KEY   = 13'h0000;
    localparam addr_t SAVE_KEY    = 13'h0F0F;
    localparam addr_t RESTORE_KEY = 13'h0F0E;
    localparam step_t LAST_PREFIX = step_t'(SEQ_LEN - 1);
    localparam step_t DONE_STEP   = step_t'(SEQ_LEN);

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SAVE,
        CMD_RESTORE
    } cmd_e;

    typedef struct packed {
        logic  rd_edge;
        logic  wr_hit;
        addr_t addr;
    } bus_evt_t;

    function automatic addr_t prefix_addr(step_t idx);
        case (idx)
            3'd0:    return START_KEY;
            3'd1:    return 13'h1555;
            3'd2:    return 13'h0AAA;
            3'd3:    return 13'h1FFF;
            3'd4:    return 13'h10F0;
            default: return START_KEY;
        endcase
    endfunction

    function automatic cmd_e decode_final(addr_t a);
        if (a == SAVE_KEY)    return CMD_SAVE;
        if (a == RESTORE_KEY) return CMD_RESTORE;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/seqcmd_edge_sync.sv
module seqcmd_edge_sync #(
    parameter int NSIG   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSIG-1:0] raw,
    output logic [NSIG-1:0] lvl,
    output logic [NSIG-1:0] fall
);

    for (genvar i = 0; i < NSIG; i++) begin : g_bit
        logic [STAGES-1:0] sh;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh   <= '1;
                prev <= 1'b1;
            end else begin
                sh   <= {sh[STAGES-2:0], raw[i]};
                prev <= sh[STAGES-1];
            end
        end

        assign lvl[i]  = sh[STAGES-1];
        assign fall[i] = prev & ~sh[STAGES-1];

        // R2: a detected edge lasts exactly one clock
        assert_edge_single_R2: assert property (@(posedge clk) disable iff (rst)
            fall[i] |=> !fall[i]);
    end

endmodule

// File: rtl/seqcmd_tracker.sv
module seqcmd_tracker
    import seqcmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     busy,
    input  logic     low_supply,
    input  bus_evt_t evt,
    output step_t    step,
    output logic     save_req,
    output logic     restore_req
);

    step_t step_q, step_d, cur;
    cmd_e  cmd_q, cmd_d;

    always_comb begin
        cur    = (step_q == DONE_STEP) ? '0 : step_q;
        step_d = cur;
        cmd_d  = CMD_NONE;
        if (busy) begin
            step_d = '0;
        end else if (evt.wr_hit) begin
            step_d = '0;
        end else if (evt.rd_edge) begin
            if (cur == LAST_PREFIX && decode_final(evt.addr) != CMD_NONE) begin
                if (decode_final(evt.addr) == CMD_SAVE && low_supply) begin
                    step_d = '0;
                end else begin
                    cmd_d  = decode_final(evt.addr);
                    step_d = DONE_STEP;
                end
            end else if (cur != LAST_PREFIX && evt.addr == prefix_addr(cur)) begin
                step_d = cur + 1'b1;
            end else if (evt.addr == START_KEY) begin
                step_d = step_t'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            cmd_q  <= CMD_NONE;
        end else begin
            step_q <= step_d;
            cmd_q  <= cmd_d;
        end
    end

    assign step        = step_q;
    assign save_req    = (cmd_q == CMD_SAVE);
    assign restore_req = (cmd_q == CMD_RESTORE);

    assert_req_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({save_req, restore_req}));

    assert_save_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        save_req |=> !save_req);

    assert_restore_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        restore_req |=> !restore_req);

    assert_step_climb_R2: assert property (@(posedge clk) disable iff (rst)
        (step_q > $past(step_q)) |-> (step_q == $past(step_q) + 1'b1));

    assert_save_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
        low_supply |=> !save_req);

    assert_busy_clear_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (step_q == '0 && !save_req && !restore_req));

    assert_write_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.wr_hit && !busy) |=> (step_q == '0));

endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
    import seqcmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              busy,
    input  logic              low_supply,
    output logic              save_req,
    output logic              restore_req,
    output logic [STEP_W-1:0] step_idx
);

    localparam int CS_BIT = 0;
    localparam int WR_BIT = 1;

    logic [1:0] ctl_lvl, ctl_fall;
    bus_evt_t   evt;

    seqcmd_edge_sync #(.NSIG(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({wr_n, cs_n}),
        .lvl  (ctl_lvl),
        .fall (ctl_fall)
    );

    always_comb begin
        evt.addr    = bus_addr;
        evt.rd_edge = ctl_fall[CS_BIT] & ctl_lvl[WR_BIT];
        evt.wr_hit  = (ctl_fall[CS_BIT] & ~ctl_lvl[WR_BIT])
                    | (ctl_fall[WR_BIT] & ~ctl_lvl[CS_BIT]);
    end

    seqcmd_tracker u_trk (
        .clk         (clk),
        .rst         (rst),
        .busy        (busy),
        .low_supply  (low_supply),
        .evt         (evt),
        .step        (step_idx),
        .save_req    (save_req),
        .restore_req (restore_req)
    );

    // R10: without a chip-select edge the progress cannot move
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctl_fall[CS_BIT] && !ctl_fall[WR_BIT] && !busy && step_idx != 3'd6)
        |=> $stable(step_idx));

endmodule

// File: tb/sim_seqcmd_detect.sv
module sim_seqcmd_detect;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        busy = 1'b0;
    logic        low_supply = 1'b0;
    logic        save_req, restore_req;
    logic [2:0]  step_idx;

    int checks = 0;
    int fails = 0;
    int save_cnt = 0;
    int rest_cnt = 0;
    int exp_step = 0;
    int exp_save = 0;
    int exp_rest = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqcmd_detect u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .cs_n(cs_n), .wr_n(wr_n),
        .busy(busy), .low_supply(low_supply), .save_req(save_req),
        .restore_req(restore_req), .step_idx(step_idx)
    );

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [12:0] chain_addr(int idx);
        case (idx)
            0: return 13'h0000;
            1: return 13'h1555;
            2: return 13'h0AAA;
            3: return 13'h1FFF;
            4: return 13'h10F0;
            default: return 13'h0000;
        endcase
    endfunction

    // Expected behaviour of one access, from the requirements
    task automatic model(logic [12:0] a, bit is_wr, bit low);
        if (busy) begin
            exp_step = 0;
        end else if (is_wr) begin
            exp_step = 0;
        end else if (exp_step == 5 && (a == 13'h0F0F || a == 13'h0F0E)) begin
            if (a == 13'h0F0E) exp_rest++;
            else if (!low) exp_save++;
            exp_step = 0;
        end else if (exp_step < 5 && a == chain_addr(exp_step)) begin
            exp_step++;
        end else begin
            exp_step = (a == 13'h0000) ? 1 : 0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && (save_req || restore_req))
            check(step_idx == 3'd6, "R3 step 6 in request clock", int'(step_idx), 6);
        if (save_req) save_cnt++;
        if (restore_req) rest_cnt++;
    end

    task automatic access(logic [12:0] a, bit is_wr);
        @(negedge clk);
        bus_addr = a;
        wr_n = ~is_wr;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        model(a, is_wr, low_supply);
    endtask

    task automatic verify(string req);
        check(int'(step_idx) == exp_step, req, int'(step_idx), exp_step);
        check(save_cnt == exp_save, {req, " save count"}, save_cnt, exp_save);
        check(rest_cnt == exp_rest, {req, " restore count"}, rest_cnt, exp_rest);
    endtask

    task automatic run_chain(int upto);
        for (int i = 0; i < upto; i++) access(chain_addr(i), 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(step_idx == 0, "R1 reset step", int'(step_idx), 0);
        check(!save_req && !restore_req, "R1 reset requests",
              int'({save_req, restore_req}), 0);

        // R2 latency: result on third rising edge after cs_n falls
        @(negedge clk);
        bus_addr = 13'h0000; cs_n = 1'b0;
        repeat (2) @(negedge clk);
        check(step_idx == 0, "R2 not yet advanced", int'(step_idx), 0);
        @(negedge clk);
        check(step_idx == 1, "R2 advanced on third edge", int'(step_idx), 1);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        exp_step = 1;
        for (int i = 1; i < 5; i++) begin
            access(chain_addr(i), 1'b0);
            verify("R2 chain progress");
        end
        access(13'h0F0F, 1'b0);
        verify("R3 save issued");

        run_chain(5);
        access(13'h0F0E, 1'b0);
        verify("R4 restore issued");

        // R5 mismatch, and 0x0000 restart
        run_chain(3);
        access(13'h0123, 1'b0);
        verify("R5 mismatch aborts");
        run_chain(4);
        access(13'h0000, 1'b0);
        verify("R5 restart at 0x0000");
        run_chain(5);
        exp_step = 0; // restart above: realign by re-running from a clean step
        access(13'h0555, 1'b0);
        verify("R5 clean");
        run_chain(5);
        access(13'h0F0D, 1'b0);
        verify("R5 wrong final address");

        // R6 writes: cs-controlled, and wr falling while selected
        run_chain(4);
        access(13'h1FFF, 1'b1);
        verify("R6 cs write abort");
        run_chain(2);
        @(negedge clk);
        bus_addr = 13'h0AAA; cs_n = 1'b0;
        repeat (4) @(negedge clk);
        check(step_idx == 3, "R6 read matched before write", int'(step_idx), 3);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check(step_idx == 0, "R6 wr fall abort", int'(step_idx), 0);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        exp_step = 0;
        verify("R6 after wr abort");

        // R7 double clocking
        run_chain(3);
        access(13'h0AAA, 1'b0);
        verify("R7 repeated step aborts");
        access(13'h0000, 1'b0);
        access(13'h0000, 1'b0);
        verify("R7 repeated first step");

        // R8 low supply
        low_supply = 1'b1;
        exp_step = 0;
        access(13'h1234, 1'b0);
        run_chain(5);
        access(13'h0F0F, 1'b0);
        verify("R8 save inhibited");
        run_chain(5);
        access(13'h0F0E, 1'b0);
        verify("R8 restore allowed");
        low_supply = 1'b0;

        // R9 busy
        run_chain(2);
        @(negedge clk); busy = 1'b1;
        repeat (2) @(negedge clk);
        check(step_idx == 0, "R9 busy clears", int'(step_idx), 0);
        run_chain(5);
        access(13'h0F0E, 1'b0);
        verify("R9 busy ignores chain");
        @(negedge clk); busy = 1'b0;
        run_chain(5);
        access(13'h0F0F, 1'b0);
        verify("R9 works after busy");

        // R10 activity with cs_n high
        run_chain(3);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bus_addr = 13'(i * 13'h0333);
            wr_n = i[0];
        end
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        verify("R10 unselected activity ignored");

        // Random traffic with a fixed seed
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            int r;
            logic [12:0] a;
            bit w;
            r = int'($urandom_range(0, 99));
            w = 1'b0;
            low_supply = ($urandom_range(0, 4) == 0);
            if (r < 55) begin
                if (exp_step == 5) a = ($urandom_range(0, 1) != 0) ? 13'h0F0F : 13'h0F0E;
                else a = chain_addr(exp_step);
            end else if (r < 70) begin
                a = 13'h0000;
            end else if (r < 80) begin
                a = chain_addr(exp_step);
                w = 1'b1;
            end else begin
                a = 13'($urandom);
            end
            access(a, w);
            verify("R2 R5 R8 random traffic");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule